// File: doc/BRIEF.md
# Aliased Hub Memory with Top-Region Write Guard

This block is the memory controller for a 20-bit byte address space (1 MB) whose physical RAM is smaller than the map. Addresses from zero up to the RAM size reach the RAM directly. The highest 16 KB of physical RAM can also be reached through a second window, the last 16 KB of the map (`0xFC000` to `0xFFFFF`). The long words at the very top of the map hold the debug interrupt vector slots. Because both windows select the same storage, data written through one window is always returned through the other.

A single guard flag protects the top 16 KB of RAM. While the flag is set, every write that lands in that storage is discarded, whether it arrives through the direct window or through the alias. Each discarded write produces a one-cycle violation pulse. Addresses that fall between the end of RAM and the start of the alias window are holes. A read of a hole returns zero, a write to a hole changes nothing, and both raise an error pulse.

The port takes one request per cycle. A request carries a 32-bit data word and four byte enables. Bits [1:0] of the address are ignored, so the array is indexed by long word. Read data comes back one cycle after the request, together with a valid strobe. The RAM size is a parameter. The default is a small size suited to elaboration, and a silicon build would typically use 512 KB.

Top module: `hubmem_mirror`

## Requirements
- R1: A request whose address is below RAM_BYTES accesses physical byte address `addr` directly. A read returns the bytes most recently written there.
- R2: An address `0xFC000 + k` (0 <= k < 16384) accesses the same physical bytes as `RAM_BYTES - 16384 + k`. A write through either address is visible to a read through the other.
- R3: An address from RAM_BYTES up to `0xFBFFF` is a hole. A read there returns `rd_valid`=1 with `rd_data`=0. A write there leaves every RAM location unchanged. In both cases `map_error` is 1 in the cycle after the request and 0 otherwise.
- R4: While the guard flag is set, a write to physical bytes `RAM_BYTES-16384` to `RAM_BYTES-1` leaves memory unchanged, through either window. `protect_violation` is 1 for exactly the cycle after each such write.
- R5: While the guard flag is set, writes below `RAM_BYTES-16384` still update memory. While the flag is clear, writes to the top region update memory and raise no violation.
- R6: The guard flag is 0 after reset. `wp_set` sets it and `wp_clr` clears it. When both are high, `wp_set` wins. A request presented in the same cycle as a strobe is judged by the old flag value. The new value applies from the next cycle.
- R7: A read request gives `rd_valid`=1 in the following cycle only. A read that immediately follows a write to the same long word returns the newly written data.
- R8: Byte lane i (`wdata[8i+7:8i]`, physical byte `long_base + i`) is written only when `req_be[i]`=1. Address bits [1:0] are ignored.
- R9: The debug vector slots at the top long words of the map (up to `0xFFFFC`) are covered by the guard flag exactly like the rest of the alias window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address in the map |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data, lane 0 in bits [7:0] |
| wp_set | input | 1 | Set the guard flag |
| wp_clr | input | 1 | Clear the guard flag |
| rd_valid | output | 1 | Read data valid (one cycle after read request) |
| rd_data | output | 32 | Read data, zero for hole reads |
| map_error | output | 1 | Previous request addressed a hole |
| protect_violation | output | 1 | Previous write was blocked by the guard |

## Verification
A faulty alias decode shows up on the first read through the opposite window. That read returns stale bytes one cycle after the request, or writes begin to leak between regions. A wrong guard flag value surfaces at the next write into the top region, either as a missing or spurious violation pulse or as changed data on a later read. Dropped or misrouted byte lanes appear on the next read of that long word. Hole reads are exposed by nonzero data or a missing error pulse. The random stream mixes every region with guard toggles, so each such fault is exposed within a few requests of when it arises.

// File: rtl/hubmem_pkg.sv
`timescale 1ns/1ps
package hubmem_pkg;

   // Where a map address lands after decode
   typedef enum logic [1:0] {
      RGN_LOW    = 2'd0,   // direct, below the guarded region
      RGN_TOP    = 2'd1,   // direct, inside the guarded region
      RGN_ALIAS  = 2'd2,   // alias window at the end of the map
      RGN_HOLE   = 2'd3    // nothing mapped
   } region_e;

   function automatic logic region_guarded(region_e r);
      return (r == RGN_TOP) || (r == RGN_ALIAS);
   endfunction

   function automatic logic region_mapped(region_e r);
      return r != RGN_HOLE;
   endfunction

endpackage

// File: rtl/hubmem_decode.sv
`timescale 1ns/1ps
module hubmem_decode
   import hubmem_pkg::*;
#(
   parameter int MAP_AW    = 20,
   parameter int RAM_BYTES = 24576,
   parameter int TOP_BYTES = 16384,
   parameter int IDX_W     = $clog2(RAM_BYTES / 4)
) (
   input  logic [MAP_AW-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output region_e           region
);
   localparam int MAP_BYTES = 1 << MAP_AW;
   localparam int ALIAS_BASE = MAP_BYTES - TOP_BYTES;
   localparam int GUARD_BASE = RAM_BYTES - TOP_BYTES;
   localparam int TOP_W = $clog2(TOP_BYTES);
   localparam logic [MAP_AW-1:0] ALIAS_BASE_A = MAP_AW'(ALIAS_BASE);
   localparam logic [MAP_AW-1:0] GUARD_BASE_A = MAP_AW'(GUARD_BASE);
   localparam logic [MAP_AW-1:0] RAM_END_A    = MAP_AW'(RAM_BYTES);
   localparam bit SPLICE_OK = ((1 << TOP_W) == TOP_BYTES) && ((GUARD_BASE % TOP_BYTES) == 0);

   logic              in_direct;
   logic              in_alias;
   logic [MAP_AW-1:0] alias_phys;
   logic [MAP_AW-1:0] phys;

   assign in_direct = addr < RAM_END_A;
   assign in_alias  = addr >= ALIAS_BASE_A;

   // Aligned guarded region: relocate by replacing upper bits; otherwise rebase with an adder
   generate
      if (SPLICE_OK) begin : g_splice
         assign alias_phys = {GUARD_BASE_A[MAP_AW-1:TOP_W], addr[TOP_W-1:0]};
      end else begin : g_rebase
         assign alias_phys = addr - ALIAS_BASE_A + GUARD_BASE_A;
      end
   endgenerate

   assign phys = in_alias ? alias_phys : addr;
   assign idx  = phys[IDX_W+1:2];

   always_comb begin
      if (in_alias)                                region = RGN_ALIAS;
      else if (in_direct && (addr >= GUARD_BASE_A)) region = RGN_TOP;
      else if (in_direct)                          region = RGN_LOW;
      else                                         region = RGN_HOLE;
   end

endmodule

// File: rtl/hubmem_wp_guard.sv
`timescale 1ns/1ps
module hubmem_wp_guard
   import hubmem_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wp_set,
   input  logic    wp_clr,
   input  logic    wr_req,
   input  region_e region,
   output logic    wp_q,
   output logic    wr_allow,
   output logic    wr_blocked
);
   // set dominates clear
   always_ff @(posedge clk) begin
      if (!rst_n)      wp_q <= 1'b0;
      else if (wp_set) wp_q <= 1'b1;
      else if (wp_clr) wp_q <= 1'b0;
   end

   logic hit_guard;
   assign hit_guard  = region_guarded(region) && wp_q;
   assign wr_blocked = wr_req && hit_guard;
   assign wr_allow   = wr_req && region_mapped(region) && !hit_guard;

endmodule

// File: rtl/hubmem_array.sv
`timescale 1ns/1ps
module hubmem_array #(
   parameter int DEPTH = 6144,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic [LANES-1:0]   be,
   input  logic [8*LANES-1:0] wdata,
   output logic [8*LANES-1:0] rdata
);
   // One byte-wide store per lane; write and read share the index
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [7:0] store [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en && be[g]) store[idx] <= wdata[8*g +: 8];
            if (rd_en)          rdata[8*g +: 8] <= store[idx];
         end
      end
   endgenerate

endmodule

// File: rtl/hubmem_mirror.sv
`timescale 1ns/1ps
module hubmem_mirror
   import hubmem_pkg::*;
#(
   parameter int MAP_AW    = 20,
   parameter int RAM_BYTES = 24576,
   parameter int TOP_BYTES = 16384
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [MAP_AW-1:0] req_addr,
   input  logic [3:0]        req_be,
   input  logic [31:0]       req_wdata,
   input  logic              wp_set,
   input  logic              wp_clr,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   output logic              map_error,
   output logic              protect_violation
);
   localparam int LANES     = 4;
   localparam int DEPTH     = RAM_BYTES / LANES;
   localparam int IDX_W     = $clog2(DEPTH);
   localparam int MAP_BYTES = 1 << MAP_AW;

   generate
      if (RAM_BYTES % LANES != 0)           begin : g_bad_ram   $error("RAM_BYTES must be long aligned");   end
      if (TOP_BYTES % LANES != 0)           begin : g_bad_top   $error("TOP_BYTES must be long aligned");   end
      if (TOP_BYTES > RAM_BYTES)            begin : g_bad_fit   $error("guarded region exceeds RAM");      end
      if (RAM_BYTES > MAP_BYTES - TOP_BYTES) begin : g_bad_map  $error("RAM overlaps the alias window");   end
   endgenerate

   region_e          region;
   logic [IDX_W-1:0] idx;
   logic             wp_q;
   logic             wr_allow;
   logic             wr_blocked;
   logic             rd_fire;
   logic [31:0]      arr_rdata;

   hubmem_decode #(
      .MAP_AW(MAP_AW), .RAM_BYTES(RAM_BYTES), .TOP_BYTES(TOP_BYTES), .IDX_W(IDX_W)
   ) dec_i (
      .addr(req_addr), .idx(idx), .region(region)
   );

   hubmem_wp_guard guard_i (
      .clk(clk), .rst_n(rst_n), .wp_set(wp_set), .wp_clr(wp_clr),
      .wr_req(req_valid && req_write), .region(region),
      .wp_q(wp_q), .wr_allow(wr_allow), .wr_blocked(wr_blocked)
   );

   assign rd_fire = req_valid && !req_write && region_mapped(region);

   hubmem_array #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .LANES(LANES)
   ) arr_i (
      .clk(clk), .wr_en(wr_allow), .rd_en(rd_fire), .idx(idx),
      .be(req_be), .wdata(req_wdata), .rdata(arr_rdata)
   );

   logic rd_q, hole_q, viol_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         hole_q <= 1'b0;
         viol_q <= 1'b0;
      end else begin
         rd_q   <= req_valid && !req_write;
         hole_q <= req_valid && !region_mapped(region);
         viol_q <= wr_blocked;
      end
   end

   assign rd_valid          = rd_q;
   assign map_error         = hole_q;
   assign protect_violation = viol_q;
   assign rd_data           = (rd_q && !hole_q) ? arr_rdata : 32'h0;

endmodule

// File: rtl/hubmem_mirror_chk.sv
`timescale 1ns/1ps
module hubmem_mirror_chk #(
   parameter int MAP_AW    = 20,
   parameter int TOP_BYTES = 16384
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [MAP_AW-1:0] req_addr,
   input logic              wp_set,
   input logic              wp_clr,
   input logic              wp_q,
   input logic              rd_valid,
   input logic [31:0]       rd_data,
   input logic              map_error,
   input logic              protect_violation
);
   localparam logic [MAP_AW-1:0] ALIAS_A = MAP_AW'((1 << MAP_AW) - TOP_BYTES);

   p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write |=> rd_valid);
   p_valid_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write));
   p_hole_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && map_error |-> rd_data == 32'h0);
   p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(map_error && protect_violation));
   p_viol_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      protect_violation |-> $past(req_valid && req_write && wp_q));
   p_alias_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && wp_q && (req_addr >= ALIAS_A) |=> protect_violation);
   p_vector_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && wp_q && (req_addr[MAP_AW-1:2] == '1) |=> protect_violation);
   p_wp_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wp_set |=> wp_q);
   p_wp_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wp_clr && !wp_set |=> !wp_q);
   p_wp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_set && !wp_clr |=> $stable(wp_q));

endmodule

bind hubmem_mirror hubmem_mirror_chk #(.MAP_AW(MAP_AW), .TOP_BYTES(TOP_BYTES)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .wp_set(wp_set), .wp_clr(wp_clr), .wp_q(wp_q),
   .rd_valid(rd_valid), .rd_data(rd_data), .map_error(map_error),
   .protect_violation(protect_violation)
);

// File: tb/hubmem_mirror_tb_top.sv
`timescale 1ns/1ps
module hubmem_mirror_tb_top;
   localparam int MAP_AW    = 20;
   localparam int RAM_BYTES = 24576;
   localparam int TOP_BYTES = 16384;
   localparam int MAP_BYTES = 1 << MAP_AW;
   localparam int ALIAS     = MAP_BYTES - TOP_BYTES;
   localparam int GBASE     = RAM_BYTES - TOP_BYTES;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        wp_set = 1'b0, wp_clr = 1'b0;
   logic        rd_valid, map_error, protect_violation;
   logic [31:0] rd_data;

   int checks = 0, errors = 0;
   logic [7:0] ref_mem [RAM_BYTES];
   logic wp_m = 1'b0;

   always #2.5 clk = ~clk;

   hubmem_mirror #(.MAP_AW(MAP_AW), .RAM_BYTES(RAM_BYTES), .TOP_BYTES(TOP_BYTES)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .wp_set(wp_set), .wp_clr(wp_clr), .rd_valid(rd_valid), .rd_data(rd_data),
      .map_error(map_error), .protect_violation(protect_violation)
   );

   function automatic int phys_of(input logic [19:0] a);
      int ai = int'(a);
      if (ai >= ALIAS)     return ai - ALIAS + GBASE;
      if (ai < RAM_BYTES)  return ai;
      return -1;
   endfunction

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // One request; results checked one cycle later, away from the edge
   task automatic op(input logic vld, input logic wr, input logic [19:0] a,
                     input logic [3:0] be, input logic [31:0] wd,
                     input logic st, input logic cl, input string tag);
      int p = phys_of(a);
      int base;
      logic e_rv, e_err, e_pv;
      logic [31:0] e_rd = 32'h0;
      base = (p < 0) ? 0 : (p & ~3);
      e_rv  = vld && !wr;
      e_err = vld && (p < 0);
      e_pv  = vld && wr && (p >= GBASE) && wp_m;
      if (vld && !wr && p >= 0)
         e_rd = {ref_mem[base+3], ref_mem[base+2], ref_mem[base+1], ref_mem[base]};
      req_valid = vld; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
      wp_set = st; wp_clr = cl;
      @(posedge clk);
      #1;
      if (vld && wr && p >= 0 && !e_pv)
         for (int i = 0; i < 4; i++) if (be[i]) ref_mem[base+i] = wd[8*i +: 8];
      if (st) wp_m = 1'b1; else if (cl) wp_m = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; wp_set = 1'b0; wp_clr = 1'b0;
      chk(rd_valid === e_rv, tag, "rd_valid", {31'd0, rd_valid}, {31'd0, e_rv});
      chk(map_error === e_err, tag, "map_error", {31'd0, map_error}, {31'd0, e_err});
      chk(protect_violation === e_pv, tag, "protect_violation",
          {31'd0, protect_violation}, {31'd0, e_pv});
      if (e_rv) chk(rd_data === e_rd, tag, "rd_data", rd_data, e_rd);
   endtask

   function automatic logic [19:0] pick_addr(input int r);
      case (r)
         0: return 20'(int'($urandom % GBASE));
         1: return 20'(GBASE + int'($urandom % TOP_BYTES));
         2: return 20'(ALIAS + int'($urandom % TOP_BYTES));
         default: return 20'(RAM_BYTES + int'($urandom % (ALIAS - RAM_BYTES)));
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250611));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset state: idle outputs low (R7)
      chk(rd_valid === 1'b0 && map_error === 1'b0 && protect_violation === 1'b0 && rd_data === 32'h0,
          "R7", "reset outputs", {28'd0, rd_valid, map_error, protect_violation, |rd_data}, 32'h0);
      // guard clear after reset: top write accepted (R6)
      op(1, 1, 20'(GBASE), 4'hF, 32'h600D_0001, 0, 0, "R6");
      // fill RAM through the direct window (R1)
      for (int i = 0; i < RAM_BYTES / 4; i++)
         op(1, 1, 20'(i * 4), 4'hF, 32'hA500_0000 ^ i * 32'h0001_0203, 0, 0, "R1");
      op(1, 0, 20'h00100, 4'h0, 32'h0, 0, 0, "R1");
      op(1, 1, 20'h00104, 4'hF, 32'h1234_5678, 0, 0, "R1");
      op(1, 0, 20'h00104, 4'h0, 32'h0, 0, 0, "R7");          // back-to-back read after write
      // alias both ways (R2)
      op(1, 1, 20'hFC010, 4'hF, 32'hCAFE_F00D, 0, 0, "R2");
      op(1, 0, 20'(GBASE + 16), 4'h0, 32'h0, 0, 0, "R2");
      op(1, 1, 20'(GBASE + 32), 4'hF, 32'hBEEF_0042, 0, 0, "R2");
      op(1, 0, 20'hFC020, 4'h0, 32'h0, 0, 0, "R2");
      // holes (R3): read, and a write whose low bits match a mapped long
      op(1, 0, 20'(RAM_BYTES), 4'h0, 32'h0, 0, 0, "R3");
      op(1, 1, 20'h08010, 4'hF, 32'hDEAD_DEAD, 0, 0, "R3");
      op(1, 0, 20'h00010, 4'h0, 32'h0, 0, 0, "R3");
      op(1, 0, 20'hFBFFC, 4'h0, 32'h0, 0, 0, "R3");
      // byte enables, low address bits ignored (R8)
      op(1, 1, 20'h00203, 4'b0101, 32'h11_22_33_44, 0, 0, "R8");
      op(1, 0, 20'h00201, 4'h0, 32'h0, 0, 0, "R8");
      // guard: set with a write in the same cycle still writes (R6)
      op(1, 1, 20'(GBASE + 64), 4'hF, 32'h0000_0001, 1, 0, "R6");
      op(1, 1, 20'(GBASE + 64), 4'hF, 32'hFFFF_FFFF, 0, 0, "R4");
      op(1, 1, 20'hFC040, 4'hF, 32'hEEEE_EEEE, 0, 0, "R4");
      op(1, 0, 20'hFC040, 4'h0, 32'h0, 0, 0, "R4");
      op(1, 1, 20'h00300, 4'hF, 32'h5555_AAAA, 0, 0, "R5");
      op(1, 0, 20'h00300, 4'h0, 32'h0, 0, 0, "R5");
      op(1, 1, 20'hFFFFC, 4'hF, 32'h0BAD_0BAD, 0, 0, "R9");
      op(1, 0, 20'hFFFFC, 4'h0, 32'h0, 0, 0, "R9");
      // clear, then both strobes together: set wins (R6)
      op(0, 0, 20'h0, 4'h0, 32'h0, 0, 1, "R6");
      op(1, 1, 20'hFFFFC, 4'hF, 32'h7EC7_0001, 1, 1, "R6");
      op(1, 1, 20'hFFFFC, 4'hF, 32'h7EC7_0002, 0, 0, "R6");
      op(1, 0, 20'(GBASE + TOP_BYTES - 4), 4'h0, 32'h0, 0, 1, "R9");
      op(1, 1, 20'(GBASE + TOP_BYTES - 4), 4'hF, 32'h7EC7_0003, 0, 0, "R5");
      op(1, 0, 20'hFFFFC, 4'h0, 32'h0, 0, 0, "R2");
      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom % 4);
         logic [19:0] a = pick_addr(r);
         logic wr = $urandom % 2 == 0;
         logic st = $urandom % 16 == 0;
         logic cl = $urandom % 16 == 1;
         string tag = (r == 3) ? "R3" : (r == 2) ? "R2" : (r == 1) ? "R4" : "R1";
         op($urandom % 8 != 0, wr, a, 4'($urandom), $urandom, st, cl, tag);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule